// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block moves received frame data into memory buffers described by a ring of descriptors. Each descriptor takes four 32-bit words at a 16-byte stride: a status word, a control word, a first-buffer address and a second-buffer address. The second-buffer address can also serve as a link to the next descriptor. After a start pulse the walker reads the descriptor at the ring base. It checks that it owns the descriptor and works out how many 32-bit words fit in the descriptor's buffers. It then takes frame beats from a valid/ready stream and writes each beat to memory. The first buffer is filled before the second.

A descriptor is closed when its buffers are full or when the frame ends. At that point the walker writes the status word back. The written status hands the descriptor back to software, marks whether the descriptor holds the first and/or the last part of a frame, and records the running byte count. The walker then moves to the next descriptor. When the frame has ended, it raises a sticky receive-complete flag unless that descriptor asks for the flag to be held off.

The stream follows these back-pressure rules. A beat is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only when an owned descriptor has buffer space left and no memory access is outstanding. The sender must hold its beat until it is taken.

The memory port works as follows. A request holds its address, direction and write data steady until `mem_ack` is seen. For a read, the data arrive in the same cycle as `mem_ack`.

Top module: `rxd_ring_walker`

## Requirements
- R1: A `start` pulse while idle loads the ring base as the current descriptor address and reads its four words at offsets 0, 4, 8 and 12.
- R2: The walker uses a descriptor only if bit 31 of its status word is 1. Otherwise it stalls with `buf_unavail` high and `s_ready` low. A later `start` clears `buf_unavail` and re-reads the same descriptor.
- R3: The first-buffer size is held in control bits 12:0 in bytes and is rounded down to whole words. Beats fill the first buffer at increasing word addresses, then the second buffer, then the next descriptor. A first-buffer size of zero sends the beats straight to the second buffer.
- R4: The second-buffer size is held in control bits 28:16 in bytes and is rounded down to whole words. It is ignored when control bit 14 (chained) is set.
- R5: Control bits 30:29 have no effect on the walk, the data placement or the written status.
- R6: The next descriptor address is chosen in this order of priority:
  - the ring base, when control bit 15 (end of ring) is set;
  - otherwise the fourth descriptor word, when chained;
  - otherwise the current address plus 16.
- R7: The status write-back goes to the descriptor's first word. Bit 31 is 0. Bit 9 is set if the descriptor holds the frame's first beat. Bit 8 is set if it holds the frame's last beat. Bits 29:16 give the frame's byte count up to the end of this descriptor. All other bits are 0.
- R8: `irq_rx` is set after the write-back of a descriptor that holds a frame's last beat, unless control bit 31 of that descriptor is set.
- R9: `irq_rx` stays high until `irq_clr` is pulsed. A new set in the same cycle as a clear wins.
- R10: `s_ready` is low whenever a memory request is outstanding, and low while idle or stalled.
- R11: While `mem_req` is high and `mem_ack` is low, the request's address, direction and write data stay unchanged in the next cycle.
- R12: After reset, `irq_rx`, `buf_unavail`, `mem_req` and `s_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking from the base, or retry a stalled descriptor |
| ring_base | input | AW | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| s_valid | input | 1 | Frame beat valid |
| s_ready | output | 1 | Walker can take a beat |
| s_data | input | 32 | Frame beat, one word |
| s_last | input | 1 | Beat ends the frame |
| irq_clr | input | 1 | Write-one-to-clear for `irq_rx` |
| irq_rx | output | 1 | Sticky receive-complete flag |
| buf_unavail | output | 1 | Stalled on a descriptor not owned |

## Verification
A table of single-frame cases varies the buffer sizes, the frame length and the control flags. The cases cover:
- a frame shorter than one descriptor;
- a frame that fills the descriptor exactly;
- a frame that spills into the next descriptor;
- sizes that need rounding down;
- a zero first buffer;
- a frame that spans three descriptors.

Each case tells apart correct fill order, correct closing of descriptors and correct byte counts. Cases with reserved bits set and with the interrupt-disable bit set are checked against their plain twins, so that only the intended difference shows. Directed runs cover the following:
- an end-of-ring wrap that meets a descriptor not yet returned by software;
- recovery after that stall;
- a chained pair whose unused second-buffer size would corrupt the linked descriptor if it were honoured;
- a memory with wait states, so that request stability is exercised.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD      = 32;
  localparam int OWN_BIT   = 31;
  localparam int DIC_BIT   = 31;
  localparam int EOR_BIT   = 15;
  localparam int CHAIN_BIT = 14;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT  = 8;
  localparam int LEN_LSB   = 16;
  localparam int SZ2_LSB   = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_LOAD, S_DATA, S_DWR, S_WB, S_STALL
  } walk_st_e;
endpackage

// File: rtl/rxd_ctl_decode.sv
module rxd_ctl_decode #(
  parameter int SZW = 13,
  parameter int CW  = SZW - 2
) (
  input  logic [31:0]   ctl_word,
  output logic          dic,
  output logic          eor,
  output logic          chain,
  output logic [CW-1:0] words1,
  output logic [CW-1:0] words2
);
  import rxd_pkg::*;

  assign dic    = ctl_word[DIC_BIT];
  assign eor    = ctl_word[EOR_BIT];
  assign chain  = ctl_word[CHAIN_BIT];
  // byte sizes rounded down to words by dropping the two low bits
  assign words1 = ctl_word[2 +: CW];
  assign words2 = chain ? '0 : ctl_word[SZ2_LSB + 2 +: CW];

  logic unused_ctl;
  assign unused_ctl = ^{ctl_word[30:29], ctl_word[13], ctl_word[17:16], ctl_word[1:0]};
endmodule

// File: rtl/rxd_next_addr.sv
module rxd_next_addr #(
  parameter int AW     = 32,
  parameter int STRIDE = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          eor,
  input  logic          chain,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (eor)        nxt = base;
    else if (chain) nxt = link;
    else            nxt = cur + AW'(STRIDE);
  end
endmodule

// File: rtl/rxd_irq_status.sv
module rxd_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end

  a_r8_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !irq);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
endmodule

// File: rtl/rxd_ring_walker.sv
module rxd_ring_walker #(
  parameter int AW     = 32,
  parameter int SZW    = 13,
  parameter int LENW   = 14,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ring_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [31:0]   s_data,
  input  logic          s_last,
  input  logic          irq_clr,
  output logic          irq_rx,
  output logic          buf_unavail
);
  import rxd_pkg::*;
  localparam int CW = SZW - 2;

  walk_st_e      state;
  logic [AW-1:0] cur, a1, a2, ptr, nxt;
  logic [31:0]   ctl_w, beat, wb_word;
  logic [CW-1:0] rem, words1, words2;
  logic [LENW-1:0] len;
  logic          buf2, first_here, in_frame, got_last;
  logic          dsc_dic, dsc_eor, dsc_chain, irq_set;

  rxd_ctl_decode #(.SZW(SZW), .CW(CW)) u_dec (
    .ctl_word(ctl_w), .dic(dsc_dic), .eor(dsc_eor), .chain(dsc_chain),
    .words1(words1), .words2(words2));

  rxd_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_nxt (
    .cur(cur), .base(ring_base), .link(a2), .eor(dsc_eor), .chain(dsc_chain),
    .nxt(nxt));

  assign irq_set = (state == S_WB) && mem_ack && got_last && !dsc_dic;

  rxd_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .irq(irq_rx));

  always_comb begin
    wb_word = '0;
    wb_word[LEN_LSB +: LENW] = len;
    wb_word[FIRST_BIT] = first_here;
    wb_word[LAST_BIT]  = got_last;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    unique case (state)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin mem_req = 1'b1; mem_addr = cur + AW'(4);  end
      S_RD2: begin mem_req = 1'b1; mem_addr = cur + AW'(8);  end
      S_RD3: begin mem_req = 1'b1; mem_addr = cur + AW'(12); end
      S_DWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr; mem_wdata = beat; end
      S_WB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = wb_word; end
      default: ;
    endcase
  end

  assign s_ready = (state == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur         <= '0;
      ctl_w       <= '0;
      a1          <= '0;
      a2          <= '0;
      ptr         <= '0;
      rem         <= '0;
      beat        <= '0;
      len         <= '0;
      buf2        <= 1'b0;
      first_here  <= 1'b0;
      in_frame    <= 1'b0;
      got_last    <= 1'b0;
      buf_unavail <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cur         <= ring_base;
          buf_unavail <= 1'b0;
          state       <= S_RD0;
        end
        S_STALL: if (start) begin
          buf_unavail <= 1'b0;
          state       <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (!mem_rdata[OWN_BIT]) begin
            buf_unavail <= 1'b1;
            state       <= S_STALL;
          end else state <= S_RD1;
        end
        S_RD1: if (mem_ack) begin ctl_w <= mem_rdata; state <= S_RD2; end
        S_RD2: if (mem_ack) begin a1 <= mem_rdata[AW-1:0]; state <= S_RD3; end
        S_RD3: if (mem_ack) begin a2 <= mem_rdata[AW-1:0]; state <= S_LOAD; end
        S_LOAD: begin
          first_here <= !in_frame;
          got_last   <= 1'b0;
          if (!in_frame) len <= '0;
          if (words1 != '0) begin
            ptr <= a1; rem <= words1; buf2 <= 1'b0; state <= S_DATA;
          end else if (words2 != '0) begin
            ptr <= a2; rem <= words2; buf2 <= 1'b1; state <= S_DATA;
          end else state <= S_WB;
        end
        S_DATA: if (s_valid) begin
          beat     <= s_data;
          got_last <= s_last;
          in_frame <= 1'b1;
          len      <= len + LENW'(4);
          state    <= S_DWR;
        end
        S_DWR: if (mem_ack) begin
          ptr <= ptr + AW'(4);
          rem <= rem - CW'(1);
          if (got_last) state <= S_WB;
          else if (rem == CW'(1)) begin
            if (!buf2 && words2 != '0) begin
              ptr <= a2; rem <= words2; buf2 <= 1'b1; state <= S_DATA;
            end else state <= S_WB;
          end else state <= S_DATA;
        end
        S_WB: if (mem_ack) begin
          cur <= nxt;
          if (got_last) in_frame <= 1'b0;
          state <= S_RD0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  a_r10_no_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_ready);
  a_r2_stall_blocks_stream: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> !s_ready);
  a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && mem_ack && dsc_eor) |=> (cur == $past(ring_base)));
endmodule

// File: tb/sim_rxd_ring_walker.sv
module sim_rxd_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WATCHDOG = 50000;

  typedef struct packed {
    logic [12:0] s1;
    logic [12:0] s2;
    logic [1:0]  rsv;
    logic        dic;
    logic [7:0]  beats;
    logic [3:0]  ndesc;
    logic        irq;
  } row_t;

  localparam row_t TBL [8] = '{
    '{13'd16, 13'd8,  2'd0, 1'b0, 8'd3, 4'd1, 1'b1},  // short frame
    '{13'd16, 13'd8,  2'd0, 1'b0, 8'd6, 4'd1, 1'b1},  // exact fill
    '{13'd16, 13'd8,  2'd0, 1'b0, 8'd7, 4'd2, 1'b1},  // spill
    '{13'd18, 13'd11, 2'd0, 1'b0, 8'd7, 4'd2, 1'b1},  // rounding
    '{13'd16, 13'd8,  2'd0, 1'b1, 8'd3, 4'd1, 1'b0},  // irq held off
    '{13'd16, 13'd8,  2'd3, 1'b0, 8'd3, 4'd1, 1'b1},  // reserved bits
    '{13'd4,  13'd4,  2'd0, 1'b0, 8'd5, 4'd3, 1'b1},  // three descriptors
    '{13'd0,  13'd8,  2'd0, 1'b0, 8'd3, 4'd2, 1'b1}   // empty first buffer
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic mem_req, mem_we, s_ready, irq_rx, buf_unavail;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mem_ack;
  logic s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic s_last = 1'b0;
  logic irq_clr = 1'b0;

  logic [31:0] mem [0:255];
  int lat = 1;
  int lat_cnt;
  int compared = 0;
  int mismatched = 0;
  int hold_err = 0;
  logic pend_prev = 1'b0;
  logic [AW-1:0] paddr;
  logic pwe;
  logic [31:0] pwd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxd_ring_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .irq_clr(irq_clr), .irq_rx(irq_rx),
    .buf_unavail(buf_unavail));

  // memory model with lat cycles of wait before ack
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lat_cnt >= lat - 1) begin
          lat_cnt <= 0;
          mem_ack <= 1'b1;
          if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
          else mem_rdata <= mem[mem_addr[9:2]];
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // R11 monitor: an unanswered request must hold its fields
  always @(negedge clk) begin
    if (rst_n && pend_prev &&
        (!mem_req || mem_addr != paddr || mem_we != pwe || mem_wdata != pwd))
      hold_err++;
    pend_prev = rst_n && mem_req && !mem_ack;
    paddr = mem_addr; pwe = mem_we; pwd = mem_wdata;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic build_ring(input logic [12:0] s1, input logic [12:0] s2,
                            input logic [1:0] rsv, input logic dic);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int k = 0; k < 4; k++) begin
      mem[4*k]   = 32'h8000_0000;
      mem[4*k+1] = {dic, rsv, s2, (k == 3), 2'b00, s1};
      mem[4*k+2] = 32'h100 + 32'(k) * 32'h40;
      mem[4*k+3] = 32'h120 + 32'(k) * 32'h40;
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; start = 1'b0; irq_clr = 1'b0; lat = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic go();
    rst_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] v0);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = v0 + 32'(i); s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  function automatic logic [31:0] wb_val(input int bytes, input logic f, input logic l);
    return (32'(bytes) << 16) | (32'(f) << 9) | (32'(l) << 8);
  endfunction

  initial begin
    row_t t;
    int cap, w1, d, j, ad, nb;
    // reset state (R12, R10)
    hold_reset();
    build_ring(13'd16, 13'd8, 2'd0, 1'b0);
    check("R12 irq_rx after reset", 32'(irq_rx), 32'd0);
    check("R12 buf_unavail after reset", 32'(buf_unavail), 32'd0);
    check("R12 mem_req after reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 s_ready low while idle", 32'(s_ready), 32'd0);

    // table of single-frame cases
    for (int r = 0; r < 8; r++) begin
      t = TBL[r];
      hold_reset();
      build_ring(t.s1, t.s2, t.rsv, t.dic);
      go();
      send_frame(int'(t.beats), 32'hA000_0000 + 32'(r) * 32'h100);
      repeat (40) @(negedge clk);
      w1 = int'(t.s1) / 4;
      cap = w1 + int'(t.s2) / 4;
      for (int k = 0; k < int'(t.ndesc); k++) begin
        nb = (k + 1) * cap;
        if (nb > int'(t.beats)) nb = int'(t.beats);
        check($sformatf("R1 R7 R5 row %0d status of descriptor %0d", r, k), mem[4*k],
              wb_val(nb * 4, k == 0, k == int'(t.ndesc) - 1));
      end
      check($sformatf("R6 row %0d next descriptor untouched", r), mem[4*int'(t.ndesc)],
            32'h8000_0000);
      for (int i = 0; i < int'(t.beats); i++) begin
        d = i / cap; j = i % cap;
        ad = (j < w1) ? 32'h100 + d * 32'h40 + 4 * j : 32'h120 + d * 32'h40 + 4 * (j - w1);
        check($sformatf("R3 R4 row %0d beat %0d placement", r, i), mem[ad >> 2],
              32'hA000_0000 + 32'(r) * 32'h100 + 32'(i));
      end
      check($sformatf("R8 row %0d irq_rx", r), 32'(irq_rx), 32'(t.irq));
    end

    // end-of-ring wrap meets a descriptor not yet returned (R6, R2, R10)
    hold_reset();
    build_ring(13'd16, 13'd0, 2'd0, 1'b0);
    mem[5] = mem[5] | 32'h0000_8000;
    go();
    send_frame(2, 32'hB000_0000);
    send_frame(2, 32'hB100_0000);
    repeat (30) @(negedge clk);
    check("R2 buf_unavail on unowned descriptor", 32'(buf_unavail), 32'd1);
    check("R10 s_ready low while stalled", 32'(s_ready), 32'd0);
    check("R2 unowned descriptor left unchanged", mem[0], wb_val(8, 1'b1, 1'b1));
    check("R6 stride successor skipped after wrap", mem[8], 32'h8000_0000);
    check("R6 second frame in descriptor 1", mem[32'h140 >> 2], 32'hB100_0000);
    mem[0] = 32'h8000_0000;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check("R2 start clears buf_unavail", 32'(buf_unavail), 32'd0);
    send_frame(2, 32'hB200_0000);
    repeat (30) @(negedge clk);
    check("R6 third frame lands at ring base buffer", mem[32'h100 >> 2], 32'hB200_0000);
    check("R2 retried descriptor written back", mem[0], wb_val(8, 1'b1, 1'b1));

    // chained pair with wait-state memory (R4, R6, R11)
    hold_reset();
    build_ring(13'd16, 13'd8, 2'd0, 1'b0);
    lat = 3;
    mem[1]  = 32'h0008_4008;   // chained, size2 field 8 (ignored), size1 8
    mem[2]  = 32'h100;
    mem[3]  = 32'h0C0;         // link
    mem[48] = 32'h8000_0000;
    mem[49] = 32'h0000_0010;
    mem[50] = 32'h180;
    mem[51] = 32'h1A0;
    go();
    send_frame(3, 32'hC000_0000);
    repeat (80) @(negedge clk);
    check("R4 chained first descriptor status", mem[0], wb_val(8, 1'b1, 1'b0));
    check("R6 linked descriptor status", mem[48], wb_val(12, 1'b0, 1'b1));
    check("R4 third beat in linked buffer", mem[32'h180 >> 2], 32'hC000_0002);
    check("R6 stride successor unused when chained", mem[4], 32'h8000_0000);
    check("R11 request held until ack", 32'(hold_err), 32'd0);

    // sticky flag and clear (R9)
    repeat (5) @(negedge clk);
    check("R9 irq_rx stays set", 32'(irq_rx), 32'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    @(negedge clk);
    check("R9 irq_clr clears irq_rx", 32'(irq_rx), 32'd0);

    summary();
    $finish;
  end
endmodule